// File: doc/BRIEF.md
# Single-Bit NAND Sector ECC Corrector

This block decides what happened to one 512-byte flash sector after it was read. It compares two 24-bit check codes. One code was stored in the spare area when the sector was written. The other was computed over the data just read. From the two codes it reports one of four outcomes: clean, a single data bit that can be repaired, a flip inside the stored check code only, or damage beyond repair. For a repairable error it gives the byte offset and the bit number of the bad bit.

A second path turns a raw 32-bit parity register value into the 24-bit code that is written to the spare area. The block also owns a small read-modify-write port to a sector buffer. After a repairable result, one request reads the faulty byte, flips the reported bit and writes the byte back. Parity accumulation over the data stream and the flash bus itself are outside this block.

Top module: `necc_corrector`

## Requirements
- R1: `pack_code` equals the bitwise inverse of {`raw_parity`[27:16], `raw_parity`[11:0]}. Raw bits 31:28 and 15:12 have no effect on it. Bits 7:0 of `pack_code` form the first byte stored, 15:8 the second and 23:16 the third.
- R2: With diff = `code_calc` XOR `code_stored`, a zero diff gives status 0 (clean), with `err_byte` and `err_bit` both 0.
- R3: When diff[11:0] XOR diff[23:12] is 12'hFFF and diff[23:15] is below SECTOR_BYTES, the status is 1 (repairable), `err_byte` is diff[23:15] and `err_bit` is diff[14:12].
- R4: A diff that passes the complement test of R3 but has diff[23:15] not below SECTOR_BYTES gives status 3 (unrecoverable).
- R5: A diff with exactly one bit set gives status 2 (check-code flip only), with `err_byte` and `err_bit` both 0.
- R6: Any other nonzero diff gives status 3, with `err_byte` and `err_bit` both 0.
- R7: `done` is high for exactly the one cycle after a cycle in which `start` is high. `status`, `err_byte` and `err_bit` are updated at that edge and are otherwise held until the next `start`.
- R8: When status is 1 and no repair is in progress, `apply_go` makes the next cycle a read cycle (`buf_rd_en` high, `buf_addr` = `err_byte`). The cycle after that is a write cycle (`buf_wr_en` and `apply_done` high, same address). In the write cycle, `buf_wdata` = `buf_rdata` XOR (1 << `err_bit`). The buffer returns read data one cycle after `buf_rd_en`.
- R9: `apply_go` is ignored when status is not 1: the buffer sees no read and no write, and its contents stay unchanged.
- R10: In reset and after it, `done`, `buf_rd_en`, `buf_wr_en` and `apply_done` are 0 and the status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_parity | input | 32 | Raw parity register value to be packed |
| pack_code | output | 24 | Inverted 24-bit code to store, low byte first |
| start | input | 1 | Classify the current code pair |
| code_stored | input | 24 | Code read back from the spare area |
| code_calc | input | 24 | Code computed over the data read |
| done | output | 1 | One-cycle pulse: result valid |
| status | output | 2 | 0 clean, 1 repairable, 2 check-code flip, 3 unrecoverable |
| err_byte | output | 9 | Byte offset of the bad bit |
| err_bit | output | 3 | Bit index inside that byte |
| apply_go | input | 1 | Request the repair of the reported bit |
| apply_done | output | 1 | High in the write-back cycle |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd_en | output | 1 | Sector buffer read strobe |
| buf_rdata | input | 8 | Read data, valid one cycle after the strobe |
| buf_wr_en | output | 1 | Sector buffer write strobe |
| buf_wdata | output | 8 | Repaired byte |

## Verification
On every cycle, the assertions check four things. Each reported outcome must agree with the code pair sampled at the preceding start. The result must stay frozen between done pulses. A repaired offset must never lie past the sector end. Each buffer write must follow its read at the same address and change exactly one bit. The exact offset and bit values can only be seen through the bench's sweeps. Those sweeps cover every 12-bit complement pattern, every single-bit and double-bit difference, a shortened-sector configuration that exercises the range test, and repairs observed in the modelled buffer.

// File: rtl/necc_pkg.sv
// Shared definitions for the sector ECC corrector.
// Assumes a two-half complementary parity code of 2*HALF_W bits.
package necc_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_FIXED    = 2'd1,
        ST_ECC_ONLY = 2'd2,
        ST_BAD      = 2'd3
    } necc_status_e;

    typedef enum logic [1:0] {
        RMW_IDLE = 2'd0,
        RMW_RD   = 2'd1,
        RMW_WR   = 2'd2
    } necc_rmw_e;

endpackage

// File: rtl/necc_code_pack.sv
// Forms the storable check code from a raw parity register value.
// Takes the low half from bits HALF_W-1:0 and the high half from a field
// starting at HI_LSB, then inverts the result so that an erased sector
// (all ones) matches its stored code. Purely combinational.
module necc_code_pack #(
    parameter int RAW_W  = 32,
    parameter int HALF_W = 12,
    parameter int HI_LSB = 16,
    localparam int CODE_W = 2 * HALF_W
) (
    input  logic [RAW_W-1:0]  raw,
    output logic [CODE_W-1:0] code
);

    logic unused_raw_bits;

    // join the two parity halves and invert for erased-page consistency
    assign code = ~{raw[HI_LSB+HALF_W-1:HI_LSB], raw[HALF_W-1:0]};

    // bits between and above the two fields carry nothing
    assign unused_raw_bits = ^{raw[RAW_W-1:HI_LSB+HALF_W], raw[HI_LSB-1:HALF_W]};

endmodule

// File: rtl/necc_syndrome.sv
// Combinational decode of a stored/computed code pair into an outcome.
// Priority: zero difference, then the complementary-halves test (with the
// sector range check), then a single flipped check bit, else unrecoverable.
// Assumes the high half carries {byte offset, bit index} of the bad bit.
module necc_syndrome
    import necc_pkg::*;
#(
    parameter int HALF_W       = 12,
    parameter int SECTOR_BYTES = 512,
    localparam int CODE_W = 2 * HALF_W,
    localparam int OFF_W  = HALF_W - 3
) (
    input  logic [CODE_W-1:0] stored,
    input  logic [CODE_W-1:0] calc,
    output necc_status_e      st,
    output logic [OFF_W-1:0]  off,
    output logic [2:0]        bitx
);

    logic [CODE_W-1:0] diff;
    logic [HALF_W-1:0] lo_half;
    logic [HALF_W-1:0] hi_half;
    logic              cmpl_ok;
    logic              single;
    logic              in_range;
    logic [OFF_W-1:0]  off_raw;

    // difference between the two codes and its halves
    assign diff    = calc ^ stored;
    assign lo_half = diff[HALF_W-1:0];
    assign hi_half = diff[CODE_W-1:HALF_W];

    // a single data-bit error makes the halves exact complements
    assign cmpl_ok = &(lo_half ^ hi_half);

    // exactly one bit set marks a flip in the check code itself
    assign single  = (diff != '0) && ((diff & (diff - 1'b1)) == '0);

    // byte offset of the bad bit and its range check against the sector
    assign off_raw  = diff[CODE_W-1:HALF_W+3];
    assign in_range = (32'(off_raw) < SECTOR_BYTES);

    // prioritised classification
    always_comb begin
        st   = ST_BAD;
        off  = '0;
        bitx = '0;
        if (diff == '0) begin
            st = ST_CLEAN;
        end else if (cmpl_ok) begin
            if (in_range) begin
                st   = ST_FIXED;
                off  = off_raw;
                bitx = diff[HALF_W+2:HALF_W];
            end
        end else if (single) begin
            st = ST_ECC_ONLY;
        end
    end

endmodule

// File: rtl/necc_classify.sv
// Registers the decoded outcome on a start strobe and raises a one-cycle
// done pulse. The outcome is held until the next start.
module necc_classify
    import necc_pkg::*;
#(
    parameter int HALF_W       = 12,
    parameter int SECTOR_BYTES = 512,
    localparam int CODE_W = 2 * HALF_W,
    localparam int OFF_W  = HALF_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] stored,
    input  logic [CODE_W-1:0] calc,
    output logic              done,
    output necc_status_e      st_q,
    output logic [OFF_W-1:0]  off_q,
    output logic [2:0]        bit_q
);

    necc_status_e     st_d;
    logic [OFF_W-1:0] off_d;
    logic [2:0]       bit_d;

    necc_syndrome #(
        .HALF_W       (HALF_W),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_syn (
        .stored (stored),
        .calc   (calc),
        .st     (st_d),
        .off    (off_d),
        .bitx   (bit_d)
    );

    // capture the result on start, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            st_q  <= ST_CLEAN;
            off_q <= '0;
            bit_q <= '0;
        end else begin
            done <= start;
            if (start) begin
                st_q  <= st_d;
                off_q <= off_d;
                bit_q <= bit_d;
            end
        end
    end

endmodule

// File: rtl/necc_flip_rmw.sv
// Two-cycle read-modify-write of one sector buffer byte: a read cycle,
// then a write cycle carrying the read data with one bit inverted.
// Assumes the buffer returns read data one cycle after the read strobe.
// Requests are taken only when idle and the last outcome was repairable.
module necc_flip_rmw
    import necc_pkg::*;
#(
    parameter int OFF_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             fix_ok,
    input  logic [OFF_W-1:0] off,
    input  logic [2:0]       bitx,
    output logic [OFF_W-1:0] buf_addr,
    output logic             buf_rd_en,
    input  logic [7:0]       buf_rdata,
    output logic             buf_wr_en,
    output logic [7:0]       buf_wdata,
    output logic             apply_done
);

    necc_rmw_e        state;
    logic [OFF_W-1:0] addr_q;
    logic [2:0]       bit_q;
    logic [7:0]       mask;

    // sequence idle -> read -> write -> idle, latching the target on entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RMW_IDLE;
            addr_q <= '0;
            bit_q  <= '0;
        end else begin
            unique case (state)
                RMW_IDLE: if (go && fix_ok) begin
                    state  <= RMW_RD;
                    addr_q <= off;
                    bit_q  <= bitx;
                end
                RMW_RD:  state <= RMW_WR;
                RMW_WR:  state <= RMW_IDLE;
                default: state <= RMW_IDLE;
            endcase
        end
    end

    // one-hot mask of the bit to invert
    for (genvar g = 0; g < 8; g++) begin : g_mask
        assign mask[g] = (bit_q == 3'(g));
    end

    // buffer strobes and repaired data
    assign buf_addr   = addr_q;
    assign buf_rd_en  = (state == RMW_RD);
    assign buf_wr_en  = (state == RMW_WR);
    assign buf_wdata  = buf_rdata ^ mask;
    assign apply_done = buf_wr_en;

endmodule

// File: rtl/necc_corrector.sv
// Top level of the sector ECC corrector: code packing, pair
// classification and the single-bit repair port.
module necc_corrector
    import necc_pkg::*;
#(
    parameter int RAW_W        = 32,
    parameter int HALF_W       = 12,
    parameter int HI_LSB       = 16,
    parameter int SECTOR_BYTES = 512,
    localparam int CODE_W = 2 * HALF_W,
    localparam int OFF_W  = HALF_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAW_W-1:0]  raw_parity,
    output logic [CODE_W-1:0] pack_code,
    input  logic              start,
    input  logic [CODE_W-1:0] code_stored,
    input  logic [CODE_W-1:0] code_calc,
    output logic              done,
    output logic [1:0]        status,
    output logic [OFF_W-1:0]  err_byte,
    output logic [2:0]        err_bit,
    input  logic              apply_go,
    output logic              apply_done,
    output logic [OFF_W-1:0]  buf_addr,
    output logic              buf_rd_en,
    input  logic [7:0]        buf_rdata,
    output logic              buf_wr_en,
    output logic [7:0]        buf_wdata
);

    necc_status_e st_q;

    necc_code_pack #(
        .RAW_W  (RAW_W),
        .HALF_W (HALF_W),
        .HI_LSB (HI_LSB)
    ) u_pack (
        .raw  (raw_parity),
        .code (pack_code)
    );

    necc_classify #(
        .HALF_W       (HALF_W),
        .SECTOR_BYTES (SECTOR_BYTES)
    ) u_cls (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .stored (code_stored),
        .calc   (code_calc),
        .done   (done),
        .st_q   (st_q),
        .off_q  (err_byte),
        .bit_q  (err_bit)
    );

    necc_flip_rmw #(
        .OFF_W (OFF_W)
    ) u_rmw (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (apply_go),
        .fix_ok     (st_q == ST_FIXED),
        .off        (err_byte),
        .bitx       (err_bit),
        .buf_addr   (buf_addr),
        .buf_rd_en  (buf_rd_en),
        .buf_rdata  (buf_rdata),
        .buf_wr_en  (buf_wr_en),
        .buf_wdata  (buf_wdata),
        .apply_done (apply_done)
    );

    // expose the outcome as a plain two-bit code
    assign status = st_q;

endmodule

// File: rtl/necc_corrector_chk.sv
// Property checker for necc_corrector, attached by bind.
module necc_corrector_chk #(
    parameter int HALF_W       = 12,
    parameter int SECTOR_BYTES = 512,
    localparam int CODE_W = 2 * HALF_W,
    localparam int OFF_W  = HALF_W - 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CODE_W-1:0] code_stored,
    input logic [CODE_W-1:0] code_calc,
    input logic              done,
    input logic [1:0]        status,
    input logic [OFF_W-1:0]  err_byte,
    input logic [2:0]        err_bit,
    input logic [OFF_W-1:0]  buf_addr,
    input logic              buf_rd_en,
    input logic              buf_wr_en,
    input logic [7:0]        buf_rdata,
    input logic [7:0]        buf_wdata
);

    logic [CODE_W-1:0] pdiff;

    // difference of the pair seen on the previous cycle
    always_ff @(posedge clk) begin
        pdiff <= code_stored ^ code_calc;
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start)); // R7

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(status) && $stable(err_byte) && $stable(err_bit))); // R7

    AST_CLEAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd0) |-> (pdiff == '0)); // R2

    AST_FIXED_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd1) |-> (&(pdiff[HALF_W-1:0] ^ pdiff[CODE_W-1:HALF_W]))); // R3

    AST_FIXED_IN_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd1) |-> (32'(err_byte) < SECTOR_BYTES)); // R4

    AST_ECC_ONLY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd2) |-> ($countones(pdiff) == 1)); // R5

    AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> ($past(buf_rd_en) && buf_addr == $past(buf_addr))); // R8

    AST_WRITE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> ($countones(buf_wdata ^ buf_rdata) == 1)); // R8

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en && buf_wr_en)); // R8

    AST_NO_ACCESS_UNLESS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |-> (status == 2'd1)); // R9

endmodule

bind necc_corrector necc_corrector_chk #(
    .HALF_W       (HALF_W),
    .SECTOR_BYTES (SECTOR_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .code_stored (code_stored),
    .code_calc   (code_calc),
    .done        (done),
    .status      (status),
    .err_byte    (err_byte),
    .err_bit     (err_bit),
    .buf_addr    (buf_addr),
    .buf_rd_en   (buf_rd_en),
    .buf_wr_en   (buf_wr_en),
    .buf_rdata   (buf_rdata),
    .buf_wdata   (buf_wdata)
);

// File: tb/tb_necc_corrector.sv
`timescale 1ns/1ps
module tb_necc_corrector;

    localparam int SHORT_SECT = 384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] raw_parity = '0;
    logic        start = 1'b0;
    logic [23:0] code_stored = '0;
    logic [23:0] code_calc = '0;
    logic        apply_go = 1'b0;

    logic [23:0] pack_code, pack_s;
    logic        done, done_s;
    logic [1:0]  status, status_s;
    logic [8:0]  err_byte, err_byte_s;
    logic [2:0]  err_bit, err_bit_s;
    logic        apply_done, apply_done_s;
    logic [8:0]  buf_addr, buf_addr_s;
    logic        buf_rd_en, buf_rd_en_s;
    logic        buf_wr_en, buf_wr_en_s;
    logic [7:0]  buf_wdata, buf_wdata_s;
    logic [7:0]  buf_rdata;

    logic [7:0] mem [512];
    logic [7:0] ref_mem [512];

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    necc_corrector dut (
        .clk(clk), .rst_n(rst_n), .raw_parity(raw_parity), .pack_code(pack_code),
        .start(start), .code_stored(code_stored), .code_calc(code_calc),
        .done(done), .status(status), .err_byte(err_byte), .err_bit(err_bit),
        .apply_go(apply_go), .apply_done(apply_done), .buf_addr(buf_addr),
        .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata), .buf_wr_en(buf_wr_en),
        .buf_wdata(buf_wdata)
    );

    necc_corrector #(.SECTOR_BYTES(SHORT_SECT)) dut_short (
        .clk(clk), .rst_n(rst_n), .raw_parity(raw_parity), .pack_code(pack_s),
        .start(start), .code_stored(code_stored), .code_calc(code_calc),
        .done(done_s), .status(status_s), .err_byte(err_byte_s), .err_bit(err_bit_s),
        .apply_go(1'b0), .apply_done(apply_done_s), .buf_addr(buf_addr_s),
        .buf_rd_en(buf_rd_en_s), .buf_rdata(8'h00), .buf_wr_en(buf_wr_en_s),
        .buf_wdata(buf_wdata_s)
    );

    // sector buffer model with one-cycle read latency
    always @(posedge clk) begin
        if (buf_rd_en) buf_rdata <= mem[buf_addr];
        if (buf_wr_en) mem[buf_addr] <= buf_wdata;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_status(input logic [23:0] d, input int sect);
        if (d == 0) return 0;
        if ((d[11:0] ^ d[23:12]) == 12'hFFF) return (int'(d >> 15) < sect) ? 1 : 3;
        if ($countones(d) == 1) return 2;
        return 3;
    endfunction

    function automatic string req_of(input int s, input logic [23:0] d);
        if (s == 0) return "R2";
        if (s == 1) return "R3";
        if (s == 2) return "R5";
        if ((d[11:0] ^ d[23:12]) == 12'hFFF) return "R4";
        return "R6";
    endfunction

    // classify one pair on both instances and check the results
    task automatic run_pair(input logic [23:0] st, input logic [23:0] ca, input bit hold_chk);
        logic [23:0] d = st ^ ca;
        int e0 = exp_status(d, 512);
        int e1 = exp_status(d, SHORT_SECT);
        int eb0 = (e0 == 1) ? int'(d >> 15) : 0;
        int ei0 = (e0 == 1) ? int'(d[14:12]) : 0;
        int eb1 = (e1 == 1) ? int'(d >> 15) : 0;
        code_stored = st;
        code_calc   = ca;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R7 done", int'(done), 1);
        chk(int'(status) == e0, req_of(e0, d), int'(status), e0);
        chk(int'(err_byte) == eb0 && int'(err_bit) == ei0, req_of(e0, d),
            int'({err_byte, err_bit}), (eb0 << 3) | ei0);
        chk(int'(status_s) == e1 && int'(err_byte_s) == eb1, req_of(e1, d),
            int'({status_s, err_byte_s}), (e1 << 9) | eb1);
        if (hold_chk) begin
            code_stored = ~st;
            @(negedge clk);
            chk(done == 1'b0, "R7 pulse", int'(done), 0);
            chk(int'(status) == e0 && int'(err_byte) == eb0, "R7 hold",
                int'({status, err_byte}), (e0 << 9) | eb0);
        end
    endtask

    task automatic run_apply(input int b, input int bi, input logic [23:0] base);
        logic [23:0] d;
        logic [11:0] h;
        h = 12'((b << 3) | bi);
        d = {h, ~h};
        run_pair(base, base ^ d, 1'b0);
        apply_go = 1'b1;
        @(negedge clk);
        apply_go = 1'b0;
        chk(buf_rd_en && int'(buf_addr) == b, "R8 read", int'(buf_addr), b);
        @(negedge clk);
        chk(buf_wr_en && apply_done, "R8 write", int'({buf_wr_en, apply_done}), 3);
        @(negedge clk);
        ref_mem[b] = ref_mem[b] ^ (8'h01 << bi);
        chk(mem[b] == ref_mem[b], "R8 data", int'(mem[b]), int'(ref_mem[b]));
        chk(mem[(b + 1) % 512] == ref_mem[(b + 1) % 512], "R8 neighbour",
            int'(mem[(b + 1) % 512]), int'(ref_mem[(b + 1) % 512]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'(i * 37) ^ 8'h5A;
            ref_mem[i] = 8'(i * 37) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!done && status == 2'd0 && !buf_rd_en && !buf_wr_en && !apply_done,
            "R10", int'({done, status, buf_rd_en, buf_wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && status == 2'd0, "R10 after", int'({done, status}), 0);

        // R1: packing, including the ignored raw bits
        for (int i = 0; i < 64; i++) begin
            logic [31:0] r = 32'(i) * 32'h9E3779B1 ^ 32'h0F0F_5A5A;
            raw_parity = r;
            #1;
            chk(pack_code == ~{r[27:16], r[11:0]}, "R1", int'(pack_code),
                int'(~{r[27:16], r[11:0]}));
            raw_parity = r ^ 32'hF000_F000;
            #1;
            chk(pack_code == ~{r[27:16], r[11:0]}, "R1 ignored", int'(pack_code),
                int'(~{r[27:16], r[11:0]}));
        end
        @(negedge clk);

        // R2: equal codes
        for (int i = 0; i < 16; i++) begin
            logic [23:0] c = 24'(i * 24'h3A5C1) ^ 24'hA5A5A5;
            run_pair(c, c, i < 4);
        end

        // R3, R4: every complement pattern on both sector sizes
        for (int h = 0; h < 4096; h++) begin
            logic [11:0] hh = 12'(h);
            logic [23:0] base = 24'(h * 24'h01F3B7);
            run_pair(base, base ^ {hh, ~hh}, (h % 512) == 0);
        end

        // R5: each single flipped check bit
        for (int k = 0; k < 24; k++) begin
            run_pair(24'h123456, 24'h123456 ^ (24'h1 << k), k < 2);
        end

        // R6: every double-bit difference and a spread of wider ones
        for (int a = 0; a < 24; a++) begin
            for (int b = a + 1; b < 24; b++) begin
                run_pair(24'hFFFFFF, 24'hFFFFFF ^ (24'h1 << a) ^ (24'h1 << b), 1'b0);
            end
        end
        for (int i = 1; i < 200; i++) begin
            run_pair(24'h0, 24'(i * 24'h2B6D37), 1'b0);
        end

        // R8: repairs observed in the buffer
        run_apply(0, 0, 24'h000000);
        run_apply(511, 7, 24'hFFFFFF);
        run_apply(200, 3, 24'h5A5A5A);
        run_apply(77, 5, 24'h0C0C0C);
        run_apply(383, 6, 24'h777777);

        // R9: request ignored after a check-code-only outcome
        run_pair(24'h000000, 24'h000100, 1'b0);
        apply_go = 1'b1;
        @(negedge clk);
        apply_go = 1'b0;
        chk(!buf_rd_en && !buf_wr_en, "R9 cycle1", int'({buf_rd_en, buf_wr_en}), 0);
        @(negedge clk);
        chk(!buf_rd_en && !buf_wr_en, "R9 cycle2", int'({buf_rd_en, buf_wr_en}), 0);
        @(negedge clk);
        chk(mem[0] == ref_mem[0], "R9 data", int'(mem[0]), int'(ref_mem[0]));

        // R9: request ignored after an unrecoverable outcome
        run_pair(24'h000000, 24'h000003, 1'b0);
        apply_go = 1'b1;
        @(negedge clk);
        apply_go = 1'b0;
        chk(!buf_rd_en && !buf_wr_en, "R9 bad", int'({buf_rd_en, buf_wr_en}), 0);
        @(negedge clk);
        chk(!buf_wr_en, "R9 bad2", int'(buf_wr_en), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule